// File: doc/BRIEF.md
# Parallel NOR Flash Mode Controller

This block models the control side of a byte-wide parallel NOR flash device. It watches four active-low bus controls: chip select, output enable, write enable and a hardware reset pin. From these it decides whether the data bus is driven and what a read returns. A read can return the contents of a small behavioural storage array, a pair of identification bytes, or a status byte while a program or erase is running. Everything is sampled on a system clock, and a separate active-low system reset initialises the block.

Commands are bytes written on the rising edge of write enable while the chip is selected. An unlock pair (0xAA then 0x55) followed by a command byte selects one of three functions. 0x90 enters identification mode. 0xA0 arms a program, and the next write performs it. 0x80 starts a full erase. The byte 0xF0 written at any time when not busy returns the controller to array reads. Program and erase are modelled by cycle counters. The hardware reset pin aborts them, keeps the bus quiet and returns the controller to array reads.

Top module: `flash_mode_ctrl`

## Requirements
- R1: After system reset the controller is in array-read mode, every location reads 0xFF, and array reads need no prior command.
- R2: While `ce_n` is high, `dout_oe` is 0 whatever `oe_n` is.
- R3: While `oe_n` is high, `dout_oe` is 0.
- R4: `dout_oe` is 1 only while `ce_n`=0, `oe_n`=0, `we_n`=1 and `hw_rst_n`=1; when `dout_oe` is 0, `dout` is 0x00.
- R5: While `hw_rst_n` is low, the bus is not driven and writes are ignored. A program or erase in progress is cancelled without changing the array, and the mode returns to array read.
- R6: After the writes 0xAA, 0x55, 0x90, reads return `MFR_CODE` at address 0, `DEV_CODE` at address 1 and 0x00 at every other address.
- R7: While a program or erase runs, reads return status. Bit 7 is the complement of bit 7 of the byte being programmed (0 during erase), bit 6 is the toggle flag, and bits 5..0 are 0.
- R8: Deselecting the device during a program or erase does not stop it, and the operation completes.
- R9: The mode changes only on a command write. Writing 0xF0, or breaking the unlock sequence, or giving an unknown third byte returns the controller to array read.
- R10: The toggle flag (status bit 6) inverts at the end of each read made while busy, so two consecutive status reads differ in bit 6.
- R11: A program keeps the controller busy for exactly `PGM_CYCLES` clocks after its write is captured, and an erase for `ERASE_CYCLES` clocks. Writes, including 0xF0, are ignored while busy.
- R12: A program clears bits only: the location becomes old AND new data. An erase sets every location to 0xFF. Both take effect when the operation completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| ce_n | input | 1 | Active-low chip select |
| oe_n | input | 1 | Active-low output enable |
| we_n | input | 1 | Active-low write enable; command captured on its rising edge |
| hw_rst_n | input | 1 | Active-low hardware reset pin (level sensitive) |
| addr | input | AW | Byte address |
| din | input | 8 | Write data |
| dout | output | 8 | Read data |
| dout_oe | output | 1 | Data bus drive enable (0 = high impedance) |

## Verification
The assertions assume the bus pins change only between clock edges. They also assume a write-enable pulse lasts at least one clock, so that each rising edge is seen once. The stimulus meets this by driving every pin at the falling clock edge and holding write enable low for a full cycle per write. Commands are issued during busy periods or while the reset pin is low only where the test means them to be ignored. Checks sample one nanosecond after the falling edge, when all state has settled.

// File: rtl/fmc_pkg.sv
package fmc_pkg;
  typedef enum logic [1:0] {
    MD_READ  = 2'd0,
    MD_IDENT = 2'd1,
    MD_ARMED = 2'd2,
    MD_BUSY  = 2'd3
  } fmc_mode_e;

  localparam logic [7:0] CMD_KEY1    = 8'hAA;
  localparam logic [7:0] CMD_KEY2    = 8'h55;
  localparam logic [7:0] CMD_IDENT   = 8'h90;
  localparam logic [7:0] CMD_PROGRAM = 8'hA0;
  localparam logic [7:0] CMD_ERASE   = 8'h80;
  localparam logic [7:0] CMD_EXIT    = 8'hF0;
endpackage

// File: rtl/fmc_busy_timer.sv
module fmc_busy_timer #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          abort,
  input  logic          start,
  input  logic [CW-1:0] load_val,
  output logic          done
);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (abort)
      cnt_d = '0;
    else if (start)
      cnt_d = load_val;
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = (cnt_q == CW'(1));

  AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (cnt_q == '0)); // R11
endmodule

// File: rtl/fmc_cmd_decode.sv
module fmc_cmd_decode
  import fmc_pkg::*;
#(
  parameter int AW           = 4,
  parameter int CW           = 5,
  parameter int PGM_CYCLES   = 8,
  parameter int ERASE_CYCLES = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hw_rst_n,
  input  logic          wr_stb,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          done,
  output fmc_mode_e     mode,
  output logic          start,
  output logic [CW-1:0] load_val,
  output logic [AW-1:0] op_addr,
  output logic [7:0]    op_data,
  output logic          op_erase
);
  fmc_mode_e     mode_q, mode_d;
  logic [1:0]    stage_q, stage_d;
  logic [AW-1:0] op_addr_d;
  logic [7:0]    op_data_d;
  logic          op_erase_d;

  always_comb begin
    mode_d     = mode_q;
    stage_d    = stage_q;
    start      = 1'b0;
    load_val   = '0;
    op_addr_d  = op_addr;
    op_data_d  = op_data;
    op_erase_d = op_erase;
    if (!hw_rst_n) begin
      mode_d  = MD_READ;
      stage_d = 2'd0;
    end else if (mode_q == MD_BUSY) begin
      if (done) mode_d = MD_READ;
    end else if (wr_stb) begin
      stage_d = 2'd0;
      if (wr_data == CMD_EXIT) begin
        mode_d = MD_READ;
      end else if (mode_q == MD_ARMED) begin
        mode_d     = MD_BUSY;
        start      = 1'b1;
        load_val   = CW'(PGM_CYCLES);
        op_addr_d  = wr_addr;
        op_data_d  = wr_data;
        op_erase_d = 1'b0;
      end else begin
        case (stage_q)
          2'd0: begin
            if (wr_data == CMD_KEY1) stage_d = 2'd1;
            else                     mode_d  = MD_READ;
          end
          2'd1: begin
            if (wr_data == CMD_KEY2) stage_d = 2'd2;
            else                     mode_d  = MD_READ;
          end
          default: begin
            case (wr_data)
              CMD_IDENT:   mode_d = MD_IDENT;
              CMD_PROGRAM: mode_d = MD_ARMED;
              CMD_ERASE: begin
                mode_d     = MD_BUSY;
                start      = 1'b1;
                load_val   = CW'(ERASE_CYCLES);
                op_data_d  = 8'hFF;
                op_erase_d = 1'b1;
              end
              default:     mode_d = MD_READ;
            endcase
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= MD_READ;
      stage_q  <= 2'd0;
      op_addr  <= '0;
      op_data  <= 8'hFF;
      op_erase <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      stage_q <= stage_d;
      if (start) begin
        op_addr  <= op_addr_d;
        op_data  <= op_data_d;
        op_erase <= op_erase_d;
      end
    end
  end

  assign mode = mode_q;

  AST_HARD_RST_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !hw_rst_n |=> (mode_q == MD_READ)); // R5
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_BUSY && !done && hw_rst_n) |=> (mode_q == MD_BUSY)); // R8
  AST_DONE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_BUSY && done && hw_rst_n) |=> (mode_q == MD_READ)); // R11
  AST_BUSY_NO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_BUSY) |=> $stable(op_addr) && $stable(op_data)); // R11
endmodule

// File: rtl/fmc_array.sv
module fmc_array #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          commit,
  input  logic          erase,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    logic       cell_en;
    logic [7:0] cell_d;
    always_comb begin
      cell_en = commit && (erase || (wr_addr == AW'(g)));
      cell_d  = erase ? 8'hFF : (mem_q[g] & wr_data);
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mem_q[g] <= 8'hFF;
      else if (cell_en) mem_q[g] <= cell_d;
    end
  end

  assign rd_data = mem_q[rd_addr];

  AST_PROG_CLEARS_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !erase) |=> ((mem_q[$past(wr_addr)] & ~$past(wr_data)) == 8'h00)); // R12
  AST_ERASE_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && erase) |=> (mem_q[0] == 8'hFF)); // R12
endmodule

// File: rtl/fmc_read_mux.sv
module fmc_read_mux
  import fmc_pkg::*;
#(
  parameter int         AW       = 4,
  parameter logic [7:0] MFR_CODE = 8'h37,
  parameter logic [7:0] DEV_CODE = 8'hA1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic          hw_rst_n,
  input  fmc_mode_e     mode,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    arr_data,
  input  logic [7:0]    op_data,
  output logic [7:0]    dout,
  output logic          dout_oe
);
  logic rd_act, rd_q, rd_end;
  logic tog_q, tog_d;
  logic [7:0] sel_data;

  assign rd_act = !ce_n && !oe_n && we_n && hw_rst_n;
  assign rd_end = rd_q && !rd_act;

  always_comb begin
    tog_d = tog_q;
    if (mode == MD_BUSY && rd_end) tog_d = ~tog_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= 1'b0;
      tog_q <= 1'b0;
    end else begin
      rd_q  <= rd_act;
      tog_q <= tog_d;
    end
  end

  always_comb begin
    case (mode)
      MD_IDENT: begin
        if (addr == AW'(0))      sel_data = MFR_CODE;
        else if (addr == AW'(1)) sel_data = DEV_CODE;
        else                     sel_data = 8'h00;
      end
      MD_BUSY: sel_data = {~op_data[7], tog_q, 6'b000000};
      default: sel_data = arr_data;
    endcase
  end

  assign dout_oe = rd_act;
  assign dout    = rd_act ? sel_data : 8'h00;

  AST_TOGGLE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_BUSY && rd_q && !rd_act) |=> (tog_q != $past(tog_q))); // R10
endmodule

// File: rtl/flash_mode_ctrl.sv
module flash_mode_ctrl
  import fmc_pkg::*;
#(
  parameter int         AW           = 4,
  parameter int         PGM_CYCLES   = 8,
  parameter int         ERASE_CYCLES = 24,
  parameter logic [7:0] MFR_CODE     = 8'h37,
  parameter logic [7:0] DEV_CODE     = 8'hA1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic          hw_rst_n,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    din,
  output logic [7:0]    dout,
  output logic          dout_oe
);
  localparam int MAXC = (PGM_CYCLES > ERASE_CYCLES) ? PGM_CYCLES : ERASE_CYCLES;
  localparam int CW   = $clog2(MAXC + 1);

  logic          we_q;
  logic          wr_stb;
  logic          done, start, commit;
  logic [CW-1:0] load_val;
  logic [AW-1:0] op_addr;
  logic [7:0]    op_data, arr_data;
  logic          op_erase;
  fmc_mode_e     mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) we_q <= 1'b1;
    else        we_q <= we_n;
  end

  assign wr_stb = we_n && !we_q && !ce_n && hw_rst_n;
  assign commit = done && hw_rst_n;

  fmc_cmd_decode #(
    .AW(AW), .CW(CW), .PGM_CYCLES(PGM_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)
  ) u_dec (
    .clk(clk), .rst_n(rst_n), .hw_rst_n(hw_rst_n), .wr_stb(wr_stb),
    .wr_addr(addr), .wr_data(din), .done(done), .mode(mode),
    .start(start), .load_val(load_val), .op_addr(op_addr),
    .op_data(op_data), .op_erase(op_erase)
  );

  fmc_busy_timer #(.CW(CW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .abort(!hw_rst_n), .start(start),
    .load_val(load_val), .done(done)
  );

  fmc_array #(.AW(AW)) u_arr (
    .clk(clk), .rst_n(rst_n), .commit(commit), .erase(op_erase),
    .wr_addr(op_addr), .wr_data(op_data), .rd_addr(addr), .rd_data(arr_data)
  );

  fmc_read_mux #(.AW(AW), .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) u_rd (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .hw_rst_n(hw_rst_n), .mode(mode), .addr(addr), .arr_data(arr_data),
    .op_data(op_data), .dout(dout), .dout_oe(dout_oe)
  );

  AST_HIZ_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> !dout_oe); // R2
  AST_HIZ_OE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dout_oe); // R3
  AST_QUIET_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    !hw_rst_n |-> (!dout_oe && !commit)); // R5
  AST_QUIET_BUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_oe |-> (dout == 8'h00)); // R4
endmodule

// File: tb/sim_flash_mode_ctrl.sv
`timescale 1ns/100ps
module sim_flash_mode_ctrl;
  localparam int AW = 4;
  localparam int PGM = 8;
  localparam int ERS = 24;
  localparam logic [7:0] MFR = 8'h37;
  localparam logic [7:0] DEV = 8'hA1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, hw_rst_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic dout_oe;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  flash_mode_ctrl #(.AW(AW), .PGM_CYCLES(PGM), .ERASE_CYCLES(ERS),
                    .MFR_CODE(MFR), .DEV_CODE(DEV)) u0 (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .hw_rst_n(hw_rst_n), .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe)
  );

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference: 0 read, 1 ident, 2 armed, 3 busy
  logic [7:0] m_mem [16];
  int m_mode, m_stage, m_cnt, m_pa;
  logic [7:0] m_pd;
  bit m_er, m_tog, m_rdq, m_weq;

  function automatic bit m_rd();
    return !ce_n && !oe_n && we_n && hw_rst_n;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_mem[i]) m_mem[i] = 8'hFF;
      m_mode = 0; m_stage = 0; m_cnt = 0; m_pa = 0; m_pd = 8'hFF;
      m_er = 0; m_tog = 0; m_rdq = 0; m_weq = 1;
    end else begin
      bit stb;
      stb = we_n && !m_weq && !ce_n && hw_rst_n;
      if (m_mode == 3 && m_rdq && !m_rd()) m_tog = !m_tog;
      if (!hw_rst_n) begin
        m_mode = 0; m_stage = 0; m_cnt = 0;
      end else if (m_mode == 3) begin
        if (m_cnt == 1) begin
          if (m_er) foreach (m_mem[i]) m_mem[i] = 8'hFF;
          else m_mem[m_pa] = m_mem[m_pa] & m_pd;
          m_mode = 0; m_cnt = 0;
        end else m_cnt--;
      end else if (stb) begin
        int st;
        st = m_stage;
        m_stage = 0;
        if (din == 8'hF0) m_mode = 0;
        else if (m_mode == 2) begin
          m_mode = 3; m_cnt = PGM; m_pa = addr; m_pd = din; m_er = 0;
        end else if (st == 0) begin
          if (din == 8'hAA) m_stage = 1; else m_mode = 0;
        end else if (st == 1) begin
          if (din == 8'h55) m_stage = 2; else m_mode = 0;
        end else begin
          if (din == 8'h90) m_mode = 1;
          else if (din == 8'hA0) m_mode = 2;
          else if (din == 8'h80) begin m_mode = 3; m_cnt = ERS; m_pd = 8'hFF; m_er = 1; end
          else m_mode = 0;
        end
      end
      m_rdq = m_rd();
      m_weq = we_n;
    end
  end

  // Per-cycle comparison, 1 ns after the falling edge
  always begin
    @(negedge clk);
    #1;
    if (rst_n) begin
      int e, a;
      string tag;
      e = 0;
      if (m_rd()) begin
        case (m_mode)
          1: e = (addr == 0) ? MFR : (addr == 1) ? DEV : 0;
          3: e = {~m_pd[7], m_tog, 6'b0};
          default: e = m_mem[addr];
        endcase
        e = e | 9'h100;
      end
      a = {dout_oe, dout};
      if (!hw_rst_n) tag = "R5";
      else if (ce_n) tag = "R2";
      else if (oe_n) tag = "R3";
      else if (!we_n) tag = "R4";
      else if (m_mode == 1) tag = "R6";
      else if (m_mode == 3) tag = "R7";
      else tag = "R1";
      check(a == e, tag, a, e);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [AW-1:0] a, logic [7:0] d);
    @(negedge clk); ce_n = 0; oe_n = 1; addr = a; din = d; we_n = 0;
    @(negedge clk); we_n = 1;
    @(negedge clk); ce_n = 1;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [7:0] d, output logic oe);
    @(negedge clk); ce_n = 0; oe_n = 0; we_n = 1; addr = a;
    #1.5; d = dout; oe = dout_oe;
    @(negedge clk); ce_n = 1; oe_n = 1;
  endtask

  task automatic unlock(logic [7:0] c);
    wr(4'h5, 8'hAA); wr(4'h2, 8'h55); wr(4'h5, c);
  endtask

  initial begin
    #(5.0 * 50000);
    check(0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d, s1, s2;
    logic oe;
    int n;
    cyc(3); rst_n = 1; cyc(2);
    // R1: reset state
    #1.5; check(dout_oe == 0, "R1", dout_oe, 0);
    rd(4'h2, d, oe); check(oe && d == 8'hFF, "R1", d, 8'hFF);
    // R2 / R3 / R4
    @(negedge clk); ce_n = 1; oe_n = 0; #1.5; check(!dout_oe, "R2", dout_oe, 0);
    @(negedge clk); ce_n = 0; oe_n = 1; #1.5; check(!dout_oe, "R3", dout_oe, 0);
    @(negedge clk); ce_n = 0; oe_n = 0; we_n = 0; #1.5; check(!dout_oe && dout == 0, "R4", dout_oe, 0);
    @(negedge clk); ce_n = 1; oe_n = 1; we_n = 1;
    // R6: identification
    unlock(8'h90);
    rd(4'h0, d, oe); check(d == MFR, "R6", d, MFR);
    rd(4'h1, d, oe); check(d == DEV, "R6", d, DEV);
    rd(4'h4, d, oe); check(oe && d == 8'h00, "R6", d, 0);
    wr(4'h0, 8'hF0);
    rd(4'h0, d, oe); check(d == 8'hFF, "R9", d, 8'hFF);
    // R7 / R10 / R12: program
    unlock(8'hA0); wr(4'h3, 8'h0F);
    rd(4'h3, s1, oe); rd(4'h3, s2, oe);
    check(s1[7] == 1'b1 && s1[5:0] == 0, "R7", s1, 8'h80);
    check(s1[6] != s2[6], "R10", s2, s1 ^ 8'h40);
    cyc(PGM + 2);
    rd(4'h3, d, oe); check(d == 8'h0F, "R12", d, 8'h0F);
    unlock(8'hA0); wr(4'h3, 8'hF3); cyc(PGM + 2);
    rd(4'h3, d, oe); check(d == 8'h03, "R12", d, 8'h03);
    // R9: broken sequences
    wr(4'h5, 8'hAA); wr(4'h2, 8'h12);
    rd(4'h0, d, oe); check(d == 8'hFF, "R9", d, 8'hFF);
    unlock(8'h90); unlock(8'h77);
    rd(4'h0, d, oe); check(d == 8'hFF, "R9", d, 8'hFF);
    // R8: deselected throughout the program
    unlock(8'hA0); wr(4'h7, 8'h3C); cyc(PGM + 3);
    rd(4'h7, d, oe); check(d == 8'h3C, "R8", d, 8'h3C);
    // R11: exit byte ignored while busy
    unlock(8'hA0); wr(4'h8, 8'h0F); wr(4'h0, 8'hF0); cyc(PGM);
    rd(4'h8, d, oe); check(d == 8'h0F, "R11", d, 8'h0F);
    // R5: hardware reset aborts and blocks
    unlock(8'hA0); wr(4'h5, 8'h00); cyc(2);
    @(negedge clk); hw_rst_n = 0; ce_n = 0; oe_n = 0; addr = 4'h5;
    #1.5; check(!dout_oe, "R5", dout_oe, 0);
    @(negedge clk); ce_n = 1; oe_n = 1;
    unlock(8'h90);
    @(negedge clk); hw_rst_n = 1; cyc(PGM + 2);
    rd(4'h5, d, oe); check(oe && d == 8'hFF, "R5", d, 8'hFF);
    rd(4'h0, d, oe); check(d == 8'hFF, "R5", d, 8'hFF);
    // R11 / R12: erase duration and effect
    unlock(8'h80);
    ce_n = 0; oe_n = 0; addr = 4'h3; n = 0;
    repeat (ERS + 4) begin
      #1;
      if (dout_oe && dout != 8'hFF) n++;
      @(negedge clk);
    end
    ce_n = 1; oe_n = 1;
    check(n == ERS, "R11", n, ERS);
    rd(4'h3, d, oe); check(d == 8'hFF, "R12", d, 8'hFF);
    rd(4'h7, d, oe); check(d == 8'hFF, "R12", d, 8'hFF);
    cyc(2);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule